// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block produces the SCL clock waveform for an I2C master. It divides a reference clock by a power of two to get an internal clock. It then times a low phase and a high phase in units of that internal clock. The phase lengths come from two 5-bit counts. To each count the block adds a fixed overhead. That overhead stands for the input synchroniser and the glitch filter on the sensed SCL line.

SCL is driven open-drain: the block either pulls the line low or releases it. The high phase is timed against the filtered level of the line, not against the release. A slave that keeps SCL low therefore stretches the high phase. One-cycle pulses at each driven SCL edge let a protocol engine change SDA after the falling edge and time its sampling against the rising edge.

Rate settings are captured while a configuration hold input is asserted. They apply once it is released.

Top module: `scl_rate_gen`

## Requirements
- R1: After `rst`, and in the cycle after any cycle in which `cfg_hold` is high, `scl_pull_low`, `scl_fall_tick` and `scl_rise_tick` are all 0 and the generator is idle.
- R2: The internal clock enable fires once every 2^`div_sel` reference cycles, counted from the release of `cfg_hold`. For example, `div_sel`=7 with a low count of 1 gives a low phase of 512 reference cycles.
- R3: With `div_sel`=0, the low phase (`scl_pull_low`=1) lasts the effective low count plus 4 internal clocks.
- R4: With `div_sel` nonzero, each phase lasts the effective count plus 3 internal clocks.
- R5: Only bits [4:0] of `low_count` and `high_count` are used, and a value of 0 there counts as 1.
- R6: `div_sel`, `low_count` and `high_count` are sampled only on edges where `cfg_hold` is high. Changes made while it is low have no effect on the waveform.
- R7: The filtered SCL level, after a reference edge, takes the value `scl_sense` had two edges earlier, but only if that value equals the sample from three edges earlier. Otherwise it keeps its value, so a one-cycle dip in `scl_sense` is ignored.
- R8: The high phase ends after the high count plus overhead internal clocks on which the filtered SCL level was high. While a slave holds SCL low, the line stays released. With `div_sel`=0 and a line that follows the driver, the high phase lasts high count + 4 + 4 reference cycles.
- R9: `scl_fall_tick` is high for exactly the first cycle of each low phase. `scl_rise_tick` is high for exactly the first cycle after each release.
- R10: A low phase starts on the first internal clock at which `run_en` is 1 while idle. If `run_en` is 0 when a high phase completes, the generator goes idle with SCL released and no further ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hold | input | 1 | Holds the generator idle and samples the rate settings |
| run_en | input | 1 | Allows SCL cycles to be generated |
| div_sel | input | 3 | Prescaler select, internal clock = reference / 2^div_sel |
| low_count | input | 8 | Low-phase count, bits [4:0] used |
| high_count | input | 8 | High-phase count, bits [4:0] used |
| scl_sense | input | 1 | Level seen on the SCL line |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_fall_tick | output | 1 | One-cycle pulse at each driven falling edge |
| scl_rise_tick | output | 1 | One-cycle pulse at each release of SCL |

## Verification
Every output is a register, so a change of state is due on the same reference edge that carries the internal clock enable. The reference model advances once per edge, reading the inputs as they stood at that edge. It is compared with the outputs 2 ns after the edge. Stimulus, including the SCL line level that follows the driver, changes only after that comparison. The model therefore sees the same three-edge filter delay that the design does.

Phase lengths are also measured in reference cycles and compared with the counts plus overhead. This is done for prescaler settings 0, 2 and 7, for a one-cycle dip on SCL, and for a long stretch of SCL held low.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    localparam int SEL_W    = 3;
    localparam int CNT_W    = 5;
    localparam int REG_W    = 8;
    localparam int LEN_W    = CNT_W + 1;
    localparam int OVH_SEL0 = 4;
    localparam int OVH_SELN = 3;
    localparam int FILT_STAGES = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] low;
        logic [CNT_W-1:0] high;
    } rate_cfg_t;

    // internal clocks in one phase: effective count plus fixed overhead
    function automatic logic [LEN_W-1:0] phase_len(input logic [CNT_W-1:0] n,
                                                   input logic [SEL_W-1:0] sel);
        logic [LEN_W-1:0] base;
        base = (n == '0) ? LEN_W'(1) : LEN_W'(n);
        return base + ((sel == '0) ? LEN_W'(OVH_SEL0) : LEN_W'(OVH_SELN));
    endfunction

endpackage

// File: rtl/sclgen_prescaler.sv
module sclgen_prescaler
    import sclgen_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [SW-1:0] sel,
    output logic          ce
);
    localparam int DIV_W = (1 << SW) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;
    logic             hit;

    assign mask = ~({DIV_W{1'b1}} << sel);
    assign hit  = (div_q == mask);
    assign ce   = !clr && hit;

    always_ff @(posedge clk) begin
        if (rst || clr || hit) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // a divided internal clock never fires on two adjacent reference cycles
    assert_ce_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (ce && (sel != '0)) |=> !ce);

endmodule

// File: rtl/sclgen_in_filter.sv
module sclgen_in_filter
    import sclgen_pkg::*;
#(
    parameter int STAGES = FILT_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic level
);
    logic [STAGES-1:0] sh_q;
    logic              lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '1;
            lvl_q <= 1'b1;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], line_in};
            if (sh_q[STAGES-1] == sh_q[STAGES-2]) begin
                lvl_q <= sh_q[STAGES-2];
            end
        end
    end

    assign level = lvl_q;

    // filtered level only moves to a value both late stages agreed on
    assert_filt_agree_R7: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != $past(lvl_q)) |-> ($past(sh_q[STAGES-2]) == lvl_q &&
                                     $past(sh_q[STAGES-1]) == lvl_q));

endmodule

// File: rtl/sclgen_phase_fsm.sv
module sclgen_phase_fsm
    import sclgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             en,
    input  logic             ce,
    input  logic             filt,
    input  logic [LEN_W-1:0] low_len,
    input  logic [LEN_W-1:0] high_len,
    output logic             drive_low,
    output logic             fall_tick,
    output logic             rise_tick
);
    phase_e           st_q, st_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic             drv_q, drv_d;
    logic             ft_d, rt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        drv_d = drv_q;
        ft_d  = 1'b0;
        rt_d  = 1'b0;
        if (ce) begin
            unique case (st_q)
                PH_IDLE: begin
                    if (en) begin
                        st_d  = PH_LOW;
                        cnt_d = LEN_W'(1);
                        drv_d = 1'b1;
                        ft_d  = 1'b1;
                    end
                end
                PH_LOW: begin
                    if (cnt_q == low_len) begin
                        st_d  = PH_HIGH;
                        cnt_d = '0;
                        drv_d = 1'b0;
                        rt_d  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (filt) begin
                        if (cnt_q + 1'b1 == high_len) begin
                            if (en) begin
                                st_d  = PH_LOW;
                                cnt_d = LEN_W'(1);
                                drv_d = 1'b1;
                                ft_d  = 1'b1;
                            end else begin
                                st_d  = PH_IDLE;
                                cnt_d = '0;
                            end
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    st_d  = PH_IDLE;
                    cnt_d = '0;
                    drv_d = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            st_q      <= PH_IDLE;
            cnt_q     <= '0;
            drv_q     <= 1'b0;
            fall_tick <= 1'b0;
            rise_tick <= 1'b0;
        end else begin
            st_q      <= st_d;
            cnt_q     <= cnt_d;
            drv_q     <= drv_d;
            fall_tick <= ft_d;
            rise_tick <= rt_d;
        end
    end

    assign drive_low = drv_q;

    // SCL drive moves only on internal clock enables
    assert_drive_on_ce_R2: assert property (@(posedge clk) disable iff (rst)
        (!ce && !hold) |=> $stable(drv_q));

    assert_fall_tick_R9: assert property (@(posedge clk) disable iff (rst)
        fall_tick |-> (drv_q && !$past(drv_q)));

    assert_rise_tick_R9: assert property (@(posedge clk) disable iff (rst)
        rise_tick |-> (!drv_q && $past(drv_q)));

    // a held-low line freezes the high phase
    assert_stretch_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_HIGH && !filt && !hold) |=> (st_q == PH_HIGH));

    assert_low_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_LOW) |-> (cnt_q <= low_len && cnt_q != '0));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import sclgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_hold,
    input  logic             run_en,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [REG_W-1:0] low_count,
    input  logic [REG_W-1:0] high_count,
    input  logic             scl_sense,
    output logic             scl_pull_low,
    output logic             scl_fall_tick,
    output logic             scl_rise_tick
);
    rate_cfg_t        cfg_q;
    logic             ce;
    logic             scl_filt;
    logic [LEN_W-1:0] low_len;
    logic [LEN_W-1:0] high_len;
    logic             unused_upper_bits;

    assign unused_upper_bits = ^{low_count[REG_W-1:CNT_W], high_count[REG_W-1:CNT_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_hold) begin
            cfg_q <= '{sel: div_sel, low: low_count[CNT_W-1:0], high: high_count[CNT_W-1:0]};
        end
    end

    assign low_len  = phase_len(cfg_q.low, cfg_q.sel);
    assign high_len = phase_len(cfg_q.high, cfg_q.sel);

    sclgen_prescaler #(.SW(SEL_W)) u_presc (
        .clk (clk),
        .rst (rst),
        .clr (cfg_hold),
        .sel (cfg_q.sel),
        .ce  (ce)
    );

    sclgen_in_filter #(.STAGES(FILT_STAGES)) u_filt (
        .clk     (clk),
        .rst     (rst),
        .line_in (scl_sense),
        .level   (scl_filt)
    );

    sclgen_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hold      (cfg_hold),
        .en        (run_en),
        .ce        (ce),
        .filt      (scl_filt),
        .low_len   (low_len),
        .high_len  (high_len),
        .drive_low (scl_pull_low),
        .fall_tick (scl_fall_tick),
        .rise_tick (scl_rise_tick)
    );

    // settings stay frozen while the hold is released
    assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        !cfg_hold |=> $stable(cfg_q));

endmodule

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_hold = 1'b0;
    logic       run_en = 1'b0;
    logic [2:0] div_sel = '0;
    logic [7:0] low_count = '0;
    logic [7:0] high_count = '0;
    logic       scl_sense = 1'b1;
    logic       scl_pull_low, scl_fall_tick, scl_rise_tick;

    always #5 clk = ~clk;

    scl_rate_gen dut (
        .clk(clk), .rst(rst), .cfg_hold(cfg_hold), .run_en(run_en),
        .div_sel(div_sel), .low_count(low_count), .high_count(high_count),
        .scl_sense(scl_sense), .scl_pull_low(scl_pull_low),
        .scl_fall_tick(scl_fall_tick), .scl_rise_tick(scl_rise_tick)
    );

    int n_checks = 0;
    int n_fail = 0;
    string cur_tag = "R1";

    // behavioural model state
    int m_q[$];
    int m_filt, m_div, m_st, m_cnt, m_drv, m_ft, m_rt, m_sel, m_lo, m_hi;

    // line stimulus and measurements
    bit stretch = 0, glitch = 0;
    int low_run = 0, high_run = 0, last_low = 0, last_high = 0, prev_pull = 0;
    bit saw_fall, saw_rise;

    function automatic int eff_len(int raw, int sel);
        int n;
        n = raw & 31;
        if (n == 0) n = 1;
        return n + ((sel == 0) ? 4 : 3);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int old_filt, p, ce, lo_len, hi_len;
        if (rst) begin
            m_q = {1, 1, 1};
            m_filt = 1; m_div = 0; m_st = 0; m_cnt = 0; m_drv = 0;
            m_ft = 0; m_rt = 0; m_sel = 0; m_lo = 0; m_hi = 0;
            return;
        end
        m_q.push_back(int'(scl_sense));
        old_filt = m_filt;
        if (m_q[$-2] == m_q[$-3]) m_filt = m_q[$-2];
        while (m_q.size() > 8) void'(m_q.pop_front());
        if (cfg_hold) begin
            m_sel = div_sel; m_lo = low_count & 31; m_hi = high_count & 31;
            m_st = 0; m_cnt = 0; m_drv = 0; m_ft = 0; m_rt = 0; m_div = 0;
            return;
        end
        m_ft = 0; m_rt = 0;
        p = 1 << m_sel;
        ce = (m_div == p - 1);
        m_div = ce ? 0 : m_div + 1;
        lo_len = eff_len(m_lo, m_sel);
        hi_len = eff_len(m_hi, m_sel);
        if (ce) begin
            case (m_st)
                0: if (run_en) begin m_drv = 1; m_cnt = 1; m_st = 1; m_ft = 1; end
                1: if (m_cnt == lo_len) begin m_drv = 0; m_cnt = 0; m_st = 2; m_rt = 1; end
                   else m_cnt++;
                default: if (old_filt == 1) begin
                    if (m_cnt + 1 == hi_len) begin
                        if (run_en) begin m_drv = 1; m_cnt = 1; m_st = 1; m_ft = 1; end
                        else begin m_st = 0; m_cnt = 0; end
                    end else m_cnt++;
                end
            endcase
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        model_step();
        chk(scl_pull_low === m_drv[0] && scl_fall_tick === m_ft[0] && scl_rise_tick === m_rt[0],
            cur_tag, {scl_pull_low, scl_fall_tick, scl_rise_tick},
            {m_drv[0], m_ft[0], m_rt[0]});
        saw_fall = scl_fall_tick;
        saw_rise = scl_rise_tick;
        if (scl_pull_low) low_run++;
        if (!scl_pull_low) high_run++;
        if (prev_pull == 1 && !scl_pull_low) begin last_low = low_run; low_run = 0; end
        if (prev_pull == 0 && scl_pull_low) begin last_high = high_run; high_run = 0; end
        prev_pull = scl_pull_low;
        scl_sense = !scl_pull_low && !stretch && !glitch;
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wait_falls(int n);
        int seen = 0;
        for (int i = 0; i < 6000 && seen < n; i++) begin
            tick();
            if (saw_fall) seen++;
        end
    endtask

    task automatic wait_rise();
        for (int i = 0; i < 6000; i++) begin
            tick();
            if (saw_rise) break;
        end
    endtask

    task automatic configure(int sel, int lo, int hi);
        cfg_hold = 1; div_sel = sel[2:0]; low_count = lo[7:0]; high_count = hi[7:0];
        wait_n(2);
        cfg_hold = 0;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int falls;
        // R1 reset state
        cur_tag = "R1";
        wait_n(3);
        chk(scl_pull_low == 0 && scl_fall_tick == 0 && scl_rise_tick == 0, "R1 reset", scl_pull_low, 0);
        rst = 0;
        wait_n(2);

        // R3 prescaler 0, low 5 -> 9 internal clocks; R8 high 3 -> 7 + 4 line delay
        cur_tag = "R3";
        configure(0, 5, 3);
        run_en = 1;
        wait_falls(3);
        chk(last_low == 9, "R3 low length", last_low, 9);
        chk(last_high == 11, "R8 high length", last_high, 11);

        // R7 one-cycle dip on SCL during high is filtered out
        cur_tag = "R7";
        wait_rise();
        wait_n(2);
        glitch = 1; tick(); glitch = 0;
        wait_falls(1);
        chk(last_high == 11, "R7 glitch ignored", last_high, 11);

        // R8 slave stretches SCL low for 40 cycles
        cur_tag = "R8";
        wait_rise();
        stretch = 1;
        falls = 0;
        for (int i = 0; i < 40; i++) begin tick(); if (saw_fall) falls++; end
        chk(falls == 0, "R8 no fall while stretched", falls, 0);
        chk(scl_pull_low == 0, "R8 line released while stretched", scl_pull_low, 0);
        stretch = 0;
        wait_falls(1);
        chk(last_high > 40, "R8 stretched high length", last_high, 41);
        wait_falls(2);

        // R4/R5 prescaler 2, upper bits set, zero count treated as 1
        cur_tag = "R4";
        configure(2, 8'hE2, 8'hE0);
        wait_falls(3);
        chk(last_low == 20, "R4 low length div4", last_low, 20);
        chk(last_high == 20, "R5 zero high count as 1", last_high, 20);

        // R6 settings changed without hold have no effect
        cur_tag = "R6";
        div_sel = 0; low_count = 31; high_count = 31;
        wait_falls(3);
        chk(last_low == 20, "R6 low unchanged", last_low, 20);
        chk(last_high == 20, "R6 high unchanged", last_high, 20);

        // R2 prescaler 7: low 1 -> 4 internal clocks of 128 cycles
        cur_tag = "R2";
        configure(7, 1, 1);
        wait_falls(3);
        chk(last_low == 512, "R2 low length div128", last_low, 512);
        chk(last_high == 512, "R2 high length div128", last_high, 512);

        // R10 disable: finish current high, then idle
        cur_tag = "R10";
        run_en = 0;
        wait_n(1200);
        falls = 0;
        for (int i = 0; i < 500; i++) begin tick(); if (saw_fall || saw_rise || scl_pull_low) falls++; end
        chk(falls == 0, "R10 idle after disable", falls, 0);
        run_en = 1;
        wait_falls(1);
        chk(scl_pull_low == 1, "R10 restart on enable", scl_pull_low, 1);

        // R9 tick alignment under prescaler 0
        cur_tag = "R9";
        configure(0, 2, 2);
        falls = 0;
        for (int i = 0; i < 200; i++) begin
            tick();
            if (saw_fall && !scl_pull_low) falls++;
            if (saw_rise && scl_pull_low) falls++;
        end
        chk(falls == 0, "R9 ticks align with edges", falls, 0);

        // R1 hold during a low phase releases SCL next cycle
        cur_tag = "R1";
        for (int i = 0; i < 50 && !scl_pull_low; i++) tick();
        cfg_hold = 1;
        tick();
        chk(scl_pull_low == 0, "R1 hold releases SCL", scl_pull_low, 0);
        wait_n(3);
        cfg_hold = 0;
        wait_n(40);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule